// File: doc/BRIEF.md
# Delay Tap Retarget Controller

This block moves a compensated programmable delay line to a new delay target while the chip is running. The delay line holds a tap count that a voltage/temperature tracking loop keeps adjusting, so a fixed tap value cannot simply be written. The controller instead reads the live count and rescales it.

A request carries the new target delay in picoseconds. The controller first turns tracking off and waits a fixed settling time. It then samples the frozen tap count and subtracts a fixed intrinsic delay from the target. It scales the sampled count by the ratio of the corrected target to the start-up delay, rounding to nearest, and saturates the result to the tap range. It writes the result with a one-cycle load strobe, waits again and turns tracking back on. A build option selects a variant for delay lines whose count carries a clock-alignment offset. In that variant the offset is removed from the count before scaling and added back afterwards. The whole block runs on the divided parameter clock with a synchronous active-high reset.

Top module: `delay_retarget_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, vtc_en is 1 and busy, done and load_stb are 0.
- R2: A request sampled while idle makes vtc_en 0 and busy 1 from the next cycle on. vtc_en stays 0 for the 10 pause cycles and through the load.
- R3: load_stb is high for exactly one cycle, the 13th cycle after the request edge (12 cycles after vtc_en first reads 0), and never while vtc_en is 1. The tap count used is the value on cnt_in during the 11th cycle after the request edge.
- R4: In the plain variant, cnt_load = round(cnt × (T − I) / D0), where cnt is the sampled count, T the requested delay, I the intrinsic delay and D0 the start-up delay. Exact halves round up.
- R5: A requested delay at or below the intrinsic delay gives cnt_load = 0 in either variant.
- R6: In the alignment variant, cnt_load = round(max(cnt − 54, 0) × (T − I) / D0) + 54. With D0 = 500, I = 0, cnt = 154 and T = 520 the result is 158. A count below 54 gives 54.
- R7: Any result above 511 is written as 511.
- R8: vtc_en returns to 1 in the 11th cycle after the strobe, together with a one-cycle done pulse. busy falls in the following cycle.
- R9: busy stays high from the request until done. Requests seen while busy are ignored, and the target loaded is the one latched at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided parameter clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Retarget request, sampled while idle |
| target_ps | input | PS_W (16) | Requested delay in picoseconds |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when tracking resumes |
| vtc_en | output | 1 | Tracking enable to the delay line |
| cnt_in | input | CNT_W (9) | Live tap count from the delay line |
| cnt_load | output | CNT_W (9) | Tap count to load |
| load_stb | output | 1 | One-cycle variable-load strobe |

## Verification
A wrong sequencer state shows up at once as vtc_en, busy, load_stb or done out of step with the cycle count since the request. The reference model compares all four on every clock, so a misplaced transition is caught in the cycle it happens. A fault in sampling or scaling shows only on cnt_load during the strobe cycle, 13 cycles after the request. The bench therefore chooses counts and targets that hit rounding, the zero case, offset clamping and saturation in both variants.

// File: rtl/drc_pkg.sv
package drc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PAUSE  = 3'd1,
      ST_CAPT   = 3'd2,
      ST_CALC   = 3'd3,
      ST_LOAD   = 3'd4,
      ST_RESUME = 3'd5,
      ST_DONE   = 3'd6
   } drc_state_e;
endpackage

// File: rtl/drc_settle_timer.sv
module drc_settle_timer #(
   parameter int unsigned CYCLES = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   generate
      if (CYCLES < 1) begin : g_bad
         $error("settle time must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == LAST);

   assert_timer_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);
   assert_timer_clear_R3: assert property (@(posedge clk) disable iff (rst)
      !run |=> (cnt_q == '0));
endmodule

// File: rtl/drc_seq_fsm.sv
module drc_seq_fsm
   import drc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       req,
   input  logic       settled,
   output drc_state_e state
);
   drc_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:   if (req) nxt = ST_PAUSE;
         ST_PAUSE:  if (settled) nxt = ST_CAPT;
         ST_CAPT:   nxt = ST_CALC;
         ST_CALC:   nxt = ST_LOAD;
         ST_LOAD:   nxt = ST_RESUME;
         ST_RESUME: if (settled) nxt = ST_DONE;
         ST_DONE:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

   assert_capt_after_pause_R3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CAPT) |-> ($past(state) == ST_PAUSE));
   assert_done_after_resume_R8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DONE) |-> ($past(state) == ST_RESUME));
endmodule

// File: rtl/drc_tap_scaler.sv
module drc_tap_scaler #(
   parameter int unsigned CNT_W     = 9,
   parameter int unsigned PS_W      = 16,
   parameter int unsigned DLY0_PS   = 500,
   parameter int unsigned INTR_PS   = 200,
   parameter int unsigned ALIGN_OFS = 54,
   parameter bit          ALIGN_EN  = 1'b0
) (
   input  logic [CNT_W-1:0] cap,
   input  logic [PS_W-1:0]  tgt,
   output logic [CNT_W-1:0] taps
);
   localparam int unsigned PW = CNT_W + PS_W;
   localparam int unsigned SW = PW + 2;
   localparam logic [CNT_W-1:0] TAP_MAX = '1;
   localparam logic [SW-1:0]    DIV     = SW'(DLY0_PS);
   localparam logic [SW-1:0]    HALF    = SW'(DLY0_PS / 2);
   localparam logic [SW-1:0]    ADDEND  = ALIGN_EN ? SW'(ALIGN_OFS) : '0;
   localparam logic [PS_W-1:0]  INTR    = PS_W'(INTR_PS);

   generate
      if (DLY0_PS == 0) begin : g_bad_dly
         $error("start-up delay must be non-zero");
      end
      if (INTR_PS >= (1 << PS_W)) begin : g_bad_intr
         $error("intrinsic delay does not fit the target width");
      end
      if (ALIGN_OFS >= (1 << CNT_W)) begin : g_bad_ofs
         $error("alignment offset exceeds the tap range");
      end
   endgenerate

   logic [CNT_W-1:0] base;

   generate
      if (ALIGN_EN) begin : g_align
         localparam logic [CNT_W-1:0] OFS = CNT_W'(ALIGN_OFS);
         always_comb base = (cap > OFS) ? (cap - OFS) : '0;
      end else begin : g_plain
         always_comb base = cap;
      end
   endgenerate

   logic            below;
   logic [PS_W-1:0] eff;
   logic [PW-1:0]   prod;
   logic [SW-1:0]   quo;
   logic [SW-1:0]   tot;

   always_comb begin
      below = (tgt <= INTR);
      eff   = below ? '0 : (tgt - INTR);
      prod  = PW'(base) * PW'(eff);
      quo   = (SW'(prod) + HALF) / DIV;
      tot   = quo + ADDEND;
      if (below)                     taps = '0;
      else if (tot > SW'(TAP_MAX))   taps = TAP_MAX;
      else                           taps = tot[CNT_W-1:0];
   end
endmodule

// File: rtl/delay_retarget_ctrl.sv
module delay_retarget_ctrl
   import drc_pkg::*;
#(
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned PS_W       = 16,
   parameter int unsigned DLY0_PS    = 500,
   parameter int unsigned INTR_PS    = 200,
   parameter int unsigned ALIGN_OFS  = 54,
   parameter bit          ALIGN_EN   = 1'b0,
   parameter int unsigned SETTLE_CYC = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic [PS_W-1:0]  target_ps,
   output logic             busy,
   output logic             done,
   output logic             vtc_en,
   input  logic [CNT_W-1:0] cnt_in,
   output logic [CNT_W-1:0] cnt_load,
   output logic             load_stb
);
   drc_state_e       state;
   logic             settled;
   logic             timer_run;
   logic [PS_W-1:0]  tgt_q;
   logic [CNT_W-1:0] cap_q;
   logic [CNT_W-1:0] res_q;
   logic [CNT_W-1:0] scaled;

   assign timer_run = (state == ST_PAUSE) || (state == ST_RESUME);

   drc_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .run     (timer_run),
      .expired (settled)
   );

   drc_seq_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .req     (req),
      .settled (settled),
      .state   (state)
   );

   drc_tap_scaler #(
      .CNT_W     (CNT_W),
      .PS_W      (PS_W),
      .DLY0_PS   (DLY0_PS),
      .INTR_PS   (INTR_PS),
      .ALIGN_OFS (ALIGN_OFS),
      .ALIGN_EN  (ALIGN_EN)
   ) u_scale (
      .cap  (cap_q),
      .tgt  (tgt_q),
      .taps (scaled)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         tgt_q <= '0;
         cap_q <= '0;
         res_q <= '0;
      end else begin
         if (state == ST_IDLE && req) tgt_q <= target_ps;
         if (state == ST_CAPT)        cap_q <= cnt_in;
         if (state == ST_CALC)        res_q <= scaled;
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);
   assign vtc_en   = (state == ST_IDLE) || (state == ST_DONE);
   assign load_stb = (state == ST_LOAD);
   assign cnt_load = res_q;

   assert_reset_state_R1: assert property (@(posedge clk)
      $past(rst) |-> (vtc_en && !busy && !done && !load_stb));
   assert_pause_on_req_R2: assert property (@(posedge clk) disable iff (rst)
      (req && !busy) |=> (!vtc_en && busy));
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
      load_stb |=> !load_stb);
   assert_strobe_paused_R3: assert property (@(posedge clk) disable iff (rst)
      load_stb |-> !vtc_en);
   assert_done_resumes_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> (vtc_en && $past(!vtc_en)));
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !busy));
   assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (busy && !done) |=> busy);
   assert_target_kept_R9: assert property (@(posedge clk) disable iff (rst)
      (busy && !done) |=> $stable(tgt_q));

   generate
      if (ALIGN_EN) begin : g_chk_align
         assert_offset_floor_R6: assert property (@(posedge clk) disable iff (rst)
            (load_stb && (tgt_q > PS_W'(INTR_PS))) |-> (cnt_load >= CNT_W'(ALIGN_OFS)));
      end
   endgenerate
endmodule

// File: tb/tb_delay_retarget_ctrl.sv
`timescale 1ns/1ps
module tb_delay_retarget_ctrl;
   localparam int D0 = 500;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0;
   logic [15:0] target = '0;
   int          comp = 150;

   logic [1:0]  busy_w, done_w, vtc_w, stb_w;
   logic [8:0]  cl_w [2];
   logic [8:0]  ci_w [2];
   int          taps [2];

   int vectors = 0;
   int miscompares = 0;
   int ph = -1;
   int tgt_lat = 0;
   int cap [2];

   always #2.5 clk = ~clk;

   assign ci_w[0] = taps[0][8:0];
   assign ci_w[1] = taps[1][8:0];

   delay_retarget_ctrl dut (
      .clk(clk), .rst(rst), .req(req), .target_ps(target),
      .busy(busy_w[0]), .done(done_w[0]), .vtc_en(vtc_w[0]),
      .cnt_in(ci_w[0]), .cnt_load(cl_w[0]), .load_stb(stb_w[0]));

   delay_retarget_ctrl #(.ALIGN_EN(1'b1), .INTR_PS(0)) dut_align (
      .clk(clk), .rst(rst), .req(req), .target_ps(target),
      .busy(busy_w[1]), .done(done_w[1]), .vtc_en(vtc_w[1]),
      .cnt_in(ci_w[1]), .cnt_load(cl_w[1]), .load_stb(stb_w[1]));

   // behavioural delay lines: follow the tracking loop while enabled
   for (genvar g = 0; g < 2; g++) begin : g_line
      always @(posedge clk) begin
         if (rst)              taps[g] <= 150;
         else if (stb_w[g])    taps[g] <= int'(cl_w[g]);
         else if (vtc_w[g])    taps[g] <= comp;
      end
   end

   function automatic int exp_count(int mode, int c, int t);
      int intr, e, b, v;
      intr = (mode != 0) ? 0 : 200;
      if (t <= intr) return 0;
      e = t - intr;
      b = (mode != 0) ? ((c > 54) ? c - 54 : 0) : c;
      v = (b * e + D0 / 2) / D0 + ((mode != 0) ? 54 : 0);
      if (v > 511) v = 511;
      return v;
   endfunction

   function automatic string count_tag(int mode, int t, int v);
      if (t <= ((mode != 0) ? 0 : 200)) return "R5";
      if (v == 511) return "R7";
      return (mode != 0) ? "R6" : "R4";
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s lane/phase %0d: actual %0d expected %0d", tag, what, ph, act, exp);
      end
   endtask

   task automatic tick();
      string tv;
      @(negedge clk);
      if (rst) ph = -1;
      else if (ph < 0) begin
         if (req) begin ph = 0; tgt_lat = int'(target); end
      end else begin
         ph++;
         if (ph == 24) ph = -1;
      end
      tv = rst ? "R1" : ((ph >= 0 && ph <= 22) ? "R2" : "R8");
      for (int i = 0; i < 2; i++) begin
         chk(tv, "vtc_en", int'(vtc_w[i]), (ph >= 0 && ph <= 22) ? 0 : 1);
         chk(rst ? "R1" : "R9", "busy", int'(busy_w[i]), (ph >= 0) ? 1 : 0);
         chk(rst ? "R1" : "R8", "done", int'(done_w[i]), (ph == 23) ? 1 : 0);
         chk(rst ? "R1" : "R3", "load_stb", int'(stb_w[i]), (ph == 12) ? 1 : 0);
         if (ph == 10) cap[i] = taps[i];
         if (ph == 12) begin
            int e;
            e = exp_count(i, cap[i], tgt_lat);
            chk(count_tag(i, tgt_lat, e), "cnt_load", int'(cl_w[i]), e);
         end
      end
   endtask

   task automatic retarget(int c, int t);
      comp = c;
      tick();
      req = 1'b1;
      target = 16'(t);
      tick();
      req = 1'b0;
      repeat (26) tick();
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : main
      repeat (3) tick();              // R1 checks during reset
      rst = 1'b0;
      repeat (2) tick();              // R1 first cycles after reset
      retarget(154, 520);             // R4 plain, R6 worked example -> 158
      retarget(154, 720);             // R4, R6
      retarget(40, 600);              // R6 clamp below offset
      retarget(300, 150);             // R5 plain below intrinsic
      retarget(300, 200);             // R5 exactly intrinsic
      retarget(511, 60000);           // R7 saturation both variants
      retarget(0, 900);               // R4 zero count, R6 gives 54
      retarget(333, 1234);            // R4 rounding
      retarget(0, 0);                 // R5 zero target in both variants
      // R9: extra request pulses with another target while busy
      comp = 200;
      tick();
      req = 1'b1; target = 16'd800;
      tick();
      req = 1'b0;
      repeat (4) tick();
      req = 1'b1; target = 16'd3000;
      tick();
      req = 1'b0;
      repeat (10) tick();
      req = 1'b1; target = 16'd50;
      tick();
      req = 1'b0;
      repeat (15) tick();
      // R9: request held high through two back-to-back sequences
      comp = 123;
      tick();
      req = 1'b1; target = 16'd640;
      repeat (30) tick();
      req = 1'b0;
      repeat (30) tick();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule